// File: doc/BRIEF.md
# Multi-Sender Message Queue with Per-Sender Drop Flags

This block is a single-receiver message queue that many on-chip agents share. Each agent pushes 32-bit words through one write strobe. The low six bits of every word carry the sender's identity, and the upper bits carry the payload. The receiver pops words in arrival order through a registered read port. A level interrupt stays high while at least one word is queued.

Every push checks for space in the same cycle it is accepted. A push that finds no room is discarded. The block then raises the drop flag belonging to the sender named in the discarded word. There is no completion interrupt. Each sender learns whether its own push landed by reading its flag bit, and it clears the bit by writing a mask of ones.

An occupancy state machine has three states: `FIFO_EMPTY`, `FIFO_PARTIAL` and `FIFO_FULL`. Its transitions are:
- **first-push**: `FIFO_EMPTY` to `FIFO_PARTIAL`.
- **fill**: `FIFO_PARTIAL` to `FIFO_FULL`, on a push alone when one slot is free.
- **drain**: `FIFO_PARTIAL` to `FIFO_EMPTY`, on a pop alone when one word is held.
- **unfill**: `FIFO_FULL` to `FIFO_PARTIAL`, on a pop alone.

All other cases hold the current state. That includes a simultaneous push and pop, and a refused push in `FIFO_FULL`.

Top module: `ipc_mbox_fifo`

## Requirements
- R1: A synchronous reset (`rst_n` low at a clock edge) empties the queue, clears all 64 drop flags and drives `irq_msg` low. After reset, reads of every address return zero.
- R2: Words pushed with `wr_en` are returned whole, all 32 bits, in the order they were pushed, by reads with `rd_addr`=0. `rd_data` shows the value selected by a read in the cycle after `rd_en`, and it holds that value until the next read.
- R3: The queue accepts 128 consecutive pushes without a pop, and no drop flag is set by them.
- R4: A push with no pop in the same cycle, made while 128 words are queued, is discarded. The discard sets drop flag N, where N = `wr_data[5:0]`. Queue contents and order are unchanged.
- R5: Flags 0..31 read at `rd_addr`=1, with flag N on bit N. Flags 32..63 read at `rd_addr`=2, with flag N on bit N-32. `rd_addr`=3 reads zero.
- R6: A clear cycle (`clr_en` high) clears each bit of flag word `clr_sel` (0 selects flags 0..31, 1 selects flags 32..63) whose `clr_mask` bit is one. Bits whose mask bit is zero are left unchanged.
- R7: When a discard sets a flag in the same cycle that a clear targets that flag, the flag ends up set.
- R8: `irq_msg` is high in every cycle after an edge that leaves at least one word queued. It goes low after the edge that pops the last word.
- R9: A pop (read at `rd_addr`=0) while the queue is empty returns zero and changes no state. The next word pushed is the next word popped.
- R10: A push and a pop in the same cycle while full both take effect. The oldest word is returned, the new word joins the tail, and no flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Push strobe |
| wr_data | input | 32 | Word to push; bits [5:0] hold the sender ID |
| rd_en | input | 1 | Read strobe; pops when `rd_addr` is 0 |
| rd_addr | input | 2 | 0 message, 1 flags 0..31, 2 flags 32..63, 3 zero |
| rd_data | output | 32 | Registered read result |
| clr_en | input | 1 | Flag clear strobe |
| clr_sel | input | 1 | Flag word selected for clearing |
| clr_mask | input | 32 | Ones clear the matching flag bits |
| irq_msg | output | 1 | High while messages are queued |

## Verification
The bench targets the following corner cases:
- **Full queue, push alone.** A design that stores this word overwrites the oldest entry. A design that flags the wrong bit reports a loss to the wrong sender.
- **Full queue, push and pop together.** A design that tests fullness before counting the pop raises a false drop flag and loses the new word.
- **Pop from an empty queue.** A design that moves its read pointer here returns stale words on later reads.
- **Clear colliding with a discard on the same flag.** A design that lets the clear win hides a lost message from its sender.
- **Clear masks and high IDs.** A partial mask that wipes the whole word, or an ID above 31 that lands in the wrong word, shows up in the flag reads.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;

    typedef enum logic [1:0] {
        FIFO_EMPTY   = 2'd0,
        FIFO_PARTIAL = 2'd1,
        FIFO_FULL    = 2'd2
    } fifo_state_e;

    localparam int MSG_READ_ADDR = 0;

endpackage

// File: rtl/mbox_occupancy_fsm.sv
module mbox_occupancy_fsm
    import ipc_mbox_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             pop_req,
    output logic             do_push,
    output logic             do_pop,
    output logic             drop,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] count,
    output logic             not_empty
);

    fifo_state_e      state_q, state_d;
    logic [CNT_W-1:0] count_q;
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Transition logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FIFO_EMPTY: begin
                if (do_push)
                    state_d = (DEPTH == 1) ? FIFO_FULL : FIFO_PARTIAL;
            end
            FIFO_PARTIAL: begin
                if (do_push && !do_pop && count_q == CNT_W'(DEPTH - 1))
                    state_d = FIFO_FULL;
                else if (do_pop && !do_push && count_q == CNT_W'(1))
                    state_d = FIFO_EMPTY;
            end
            FIFO_FULL: begin
                if (do_pop && !do_push)
                    state_d = (DEPTH == 1) ? FIFO_EMPTY : FIFO_PARTIAL;
            end
            default: state_d = FIFO_EMPTY;
        endcase
    end

    // State register with counters and pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= FIFO_EMPTY;
            count_q  <= '0;
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else begin
            state_q <= state_d;
            if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
            if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
            if (do_push && !do_pop)      count_q <= count_q + 1'b1;
            else if (do_pop && !do_push) count_q <= count_q - 1'b1;
        end
    end

    // Outputs
    always_comb begin
        do_pop    = pop_req && (state_q != FIFO_EMPTY);
        do_push   = push_req && ((state_q != FIFO_FULL) || do_pop);
        drop      = push_req && !do_push;
        not_empty = (state_q != FIFO_EMPTY);
        wr_ptr    = wr_ptr_q;
        rd_ptr    = rd_ptr_q;
        count     = count_q;
    end

endmodule

// File: rtl/mbox_store.sv
module mbox_store #(
    parameter int DEPTH  = 128,
    parameter int WORD_W = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/mbox_ovf_flags.sv
module mbox_ovf_flags #(
    parameter int ID_W   = 6,
    parameter int FLAG_W = 32,
    localparam int NUM_IDS  = 1 << ID_W,
    localparam int NUM_REGS = NUM_IDS / FLAG_W,
    localparam int SEL_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  logic [ID_W-1:0]    set_id,
    input  logic               clr_en,
    input  logic [SEL_W-1:0]   clr_sel,
    input  logic [FLAG_W-1:0]  clr_mask,
    output logic [NUM_IDS-1:0] flags
);

    logic [NUM_IDS-1:0] flags_q;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
        logic [FLAG_W-1:0] set_vec, clr_vec;

        always_comb begin
            set_vec = '0;
            for (int b = 0; b < FLAG_W; b++)
                if (set_en && set_id == ID_W'(r * FLAG_W + b)) set_vec[b] = 1'b1;
            clr_vec = (clr_en && clr_sel == SEL_W'(r)) ? clr_mask : '0;
        end

        // A set in the same cycle as a clear keeps the bit high
        always_ff @(posedge clk) begin
            if (!rst_n) flags_q[r*FLAG_W +: FLAG_W] <= '0;
            else flags_q[r*FLAG_W +: FLAG_W] <=
                     (flags_q[r*FLAG_W +: FLAG_W] & ~clr_vec) | set_vec;
        end
    end

    assign flags = flags_q;

endmodule

// File: rtl/ipc_mbox_fifo.sv
module ipc_mbox_fifo
    import ipc_mbox_pkg::*;
#(
    parameter int DEPTH  = 128,
    parameter int WORD_W = 32,
    parameter int ID_W   = 6,
    parameter int FLAG_W = 32,
    localparam int NUM_IDS  = 1 << ID_W,
    localparam int NUM_REGS = NUM_IDS / FLAG_W,
    localparam int SEL_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int RA_W     = $clog2(NUM_REGS + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [RA_W-1:0]   rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              clr_en,
    input  logic [SEL_W-1:0]  clr_sel,
    input  logic [FLAG_W-1:0] clr_mask,
    output logic              irq_msg
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic               pop_req, do_push, do_pop, drop, not_empty;
    logic [PTR_W-1:0]   wr_ptr, rd_ptr;
    logic [CNT_W-1:0]   occupancy;
    logic [WORD_W-1:0]  head_word, rd_mux, rd_data_q;
    logic [NUM_IDS-1:0] ovf_flags;

    assign pop_req = rd_en && (rd_addr == RA_W'(MSG_READ_ADDR));

    mbox_occupancy_fsm #(.DEPTH(DEPTH)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (wr_en),
        .pop_req   (pop_req),
        .do_push   (do_push),
        .do_pop    (do_pop),
        .drop      (drop),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .count     (occupancy),
        .not_empty (not_empty)
    );

    mbox_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
        .clk   (clk),
        .we    (do_push),
        .waddr (wr_ptr),
        .wdata (wr_data),
        .raddr (rd_ptr),
        .rdata (head_word)
    );

    mbox_ovf_flags #(.ID_W(ID_W), .FLAG_W(FLAG_W)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (drop),
        .set_id   (wr_data[ID_W-1:0]),
        .clr_en   (clr_en),
        .clr_sel  (clr_sel),
        .clr_mask (clr_mask),
        .flags    (ovf_flags)
    );

    // Read selection: message head, then one flag word per address
    always_comb begin
        rd_mux = '0;
        if (rd_addr == RA_W'(MSG_READ_ADDR) && not_empty) rd_mux = head_word;
        for (int r = 0; r < NUM_REGS; r++)
            if (rd_addr == RA_W'(r + 1))
                rd_mux = WORD_W'(ovf_flags[r*FLAG_W +: FLAG_W]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data_q <= '0;
        else if (rd_en) rd_data_q <= rd_mux;
    end

    assign rd_data = rd_data_q;
    assign irq_msg = not_empty;

endmodule

// File: rtl/ipc_mbox_checker.sv
module ipc_mbox_checker #(
    parameter int DEPTH   = 128,
    parameter int ID_W    = 6,
    parameter int CNT_W   = 8,
    parameter int RA_W    = 2,
    parameter int WORD_W  = 32,
    parameter int NUM_IDS = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [WORD_W-1:0]  wr_data,
    input logic               rd_en,
    input logic [RA_W-1:0]    rd_addr,
    input logic               clr_en,
    input logic               irq_msg,
    input logic [CNT_W-1:0]   occ,
    input logic [NUM_IDS-1:0] flags
);

    logic pop;
    assign pop = rd_en && (rd_addr == '0);

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (occ == '0 && flags == '0 && !irq_msg));

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH));

    assert_drop_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !pop && occ == CNT_W'(DEPTH))
        |=> (flags[$past(wr_data[ID_W-1:0])] && occ == CNT_W'(DEPTH)));

    assert_flags_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !clr_en) |=> $stable(flags));

    assert_irq_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_msg == (occ != '0));

    assert_empty_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !wr_en && occ == '0) |=> (occ == '0));

    assert_full_swap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && wr_en && occ == CNT_W'(DEPTH))
        |=> (occ == CNT_W'(DEPTH) && (clr_en || $past(clr_en) || $stable(flags))));

endmodule

bind ipc_mbox_fifo ipc_mbox_checker #(
    .DEPTH(DEPTH), .ID_W(ID_W), .CNT_W(CNT_W), .RA_W(RA_W),
    .WORD_W(WORD_W), .NUM_IDS(NUM_IDS)
) u_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .clr_en  (clr_en),
    .irq_msg (irq_msg),
    .occ     (occupancy),
    .flags   (ovf_flags)
);

// File: tb/ipc_mbox_fifo_test.sv
module ipc_mbox_fifo_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 128;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, rd_en, clr_en;
    logic [31:0] wr_data, clr_mask, rd_data;
    logic [1:0]  rd_addr;
    logic [0:0]  clr_sel;
    logic        irq_msg;

    int checks = 0;
    int fails  = 0;

    logic [31:0] model_q [$];
    logic [63:0] model_flags;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ipc_mbox_fifo uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .clr_en(clr_en), .clr_sel(clr_sel), .clr_mask(clr_mask),
        .irq_msg(irq_msg)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_read(input logic [1:0] a);
        case (a)
            2'd0:    return (model_q.size() > 0) ? model_q[0] : 32'h0;
            2'd1:    return model_flags[31:0];
            2'd2:    return model_flags[63:32];
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] make_word(input logic [5:0] id);
        return {$urandom()} << 6 | 32'(id);
    endfunction

    // One bus cycle; inputs change 1 time unit after the edge
    task automatic cyc(input bit w, input logic [31:0] wd, input bit r,
                       input logic [1:0] ra, input bit c, input bit cs,
                       input logic [31:0] cm, input string tag);
        logic [31:0] exp_rd;
        bit full, pop;
        wr_en = w; wr_data = wd; rd_en = r; rd_addr = ra;
        clr_en = c; clr_sel = cs; clr_mask = cm;
        exp_rd = expect_read(ra);
        full = (model_q.size() == DEPTH);
        pop  = r && ra == 2'd0;
        @(posedge clk);
        #1;
        if (pop && model_q.size() > 0) void'(model_q.pop_front());
        if (c) begin
            if (cs) model_flags[63:32] &= ~cm;
            else    model_flags[31:0]  &= ~cm;
        end
        if (w) begin
            if (!full || pop) model_q.push_back(wd);
            else model_flags[wd[5:0]] = 1'b1;
        end
        wr_en = 0; rd_en = 0; clr_en = 0;
        if (r) check(tag, rd_data, exp_rd);
        check("R8 irq", 32'(irq_msg), 32'(model_q.size() > 0));
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] w0, w1, w2;
        void'($urandom(32'h1234_5678));
        rst_n = 0; wr_en = 0; rd_en = 0; clr_en = 0;
        wr_data = 0; rd_addr = 0; clr_sel = 0; clr_mask = 0;
        model_flags = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        check("R1 irq after reset", 32'(irq_msg), 32'h0);
        for (int a = 0; a < 4; a++) cyc(0, 0, 1, 2'(a), 0, 0, 0, "R1 read after reset");

        // R9: empty pop, then push/pop stays consistent
        cyc(0, 0, 1, 0, 0, 0, 0, "R9 empty pop");
        w0 = make_word(6'd3);
        cyc(1, w0, 0, 0, 0, 0, 0, "R9");
        cyc(0, 0, 1, 0, 0, 0, 0, "R9 word after empty pop");

        // R2: ordering of several words
        w0 = make_word(6'd1); w1 = make_word(6'd33); w2 = 32'hFFFF_FFC0 | 32'd62;
        cyc(1, w0, 0, 0, 0, 0, 0, "R2");
        cyc(1, w1, 1, 0, 0, 0, 0, "R2 first out");
        cyc(1, w2, 1, 0, 0, 0, 0, "R2 second out");
        cyc(0, 0, 1, 0, 0, 0, 0, "R2 third out");
        cyc(0, 0, 1, 0, 0, 0, 0, "R9 pop after drain");

        // R3: fill to capacity
        for (int i = 0; i < DEPTH; i++) cyc(1, make_word(6'(i % 64)), 0, 0, 0, 0, 0, "R3");
        cyc(0, 0, 1, 1, 0, 0, 0, "R3 no flag low");
        cyc(0, 0, 1, 2, 0, 0, 0, "R3 no flag high");

        // R4/R5: discards
        cyc(1, make_word(6'd5),  0, 0, 0, 0, 0, "R4");
        cyc(1, make_word(6'd40), 0, 0, 0, 0, 0, "R4");
        cyc(0, 0, 1, 1, 0, 0, 0, "R5 low word bit 5");
        cyc(0, 0, 1, 2, 0, 0, 0, "R5 high word bit 8");
        cyc(0, 0, 1, 3, 0, 0, 0, "R5 unused address");

        // R10: swap while full
        cyc(1, make_word(6'd9), 1, 0, 0, 0, 0, "R10 swap head");
        cyc(0, 0, 1, 1, 0, 0, 0, "R10 no new flag");

        // R7: discard and clear on the same flag
        cyc(1, make_word(6'd7), 0, 0, 1, 0, 32'h0000_0080, "R7");
        cyc(0, 0, 1, 1, 0, 0, 0, "R7 set wins");

        // R6: partial clear, and zero mask
        cyc(0, 0, 0, 0, 1, 0, 32'h0000_0020, "R6");
        cyc(0, 0, 1, 1, 0, 0, 0, "R6 only bit 5 cleared");
        cyc(0, 0, 0, 0, 1, 1, 32'h0, "R6");
        cyc(0, 0, 1, 2, 0, 0, 0, "R6 zero mask keeps bits");

        // R8: drain to empty, checking order
        while (model_q.size() > 0) cyc(0, 0, 1, 0, 0, 0, 0, "R2 drain order");
        cyc(0, 0, 1, 0, 0, 0, 0, "R9 empty after drain");

        // Random traffic
        for (int i = 0; i < 6000; i++) begin
            int unsigned p;
            bit w, r, c;
            logic [1:0] ra;
            p  = $urandom_range(99);
            w  = (i % 1000 < 600) ? (p < 70) : (p < 30);
            r  = ($urandom_range(99) < 45);
            ra = ($urandom_range(3) == 0) ? 2'($urandom_range(3)) : 2'd0;
            c  = ($urandom_range(9) == 0);
            cyc(w, make_word(6'($urandom_range(63))), r, ra, c,
                1'($urandom_range(1)), $urandom(), "R2/R4/R6 random");
        end

        // R1: reset in the middle of traffic
        cyc(1, make_word(6'd2), 0, 0, 0, 0, 0, "R1");
        rst_n = 0;
        @(posedge clk); #1 rst_n = 1;
        model_q.delete(); model_flags = '0;
        check("R1 irq after mid reset", 32'(irq_msg), 32'h0);
        cyc(0, 0, 1, 1, 0, 0, 0, "R1 flags after mid reset");
        cyc(0, 0, 1, 0, 0, 0, 0, "R1 empty after mid reset");

        finish_run();
    end

endmodule